// File: doc/BRIEF.md
# Reference-Switch Phase Step Absorber

This block sits between a two-way reference selector and a digital PLL. It forwards the chosen reference, primary or secondary, through a programmable per-edge delay. The PLL therefore always locks to a delayed "virtual reference" and never to the raw input. References and the PLL feedback arrive as single-cycle pulses on a fast system clock, and every delay and measurement is counted in cycles of that clock.

When the select input changes, a controller places the PLL in free-run. It waits for an edge on the newly chosen reference and counts the cycles until the next feedback edge. It stores that count as the new delay and then hands the PLL back to normal tracking. Because the new virtual reference sits at the same offset from its input edge as the feedback does, the PLL sees no phase step. The required 1 µs bound is 20 cycles at a 20 MHz system clock; this design lands the new edge on the feedback offset itself. An enable input turns the correction off, and a clear input returns the stored delay to zero.

Top module: `ref_step_absorber`

## Requirements
- R1: Only the reference chosen by `sel` (0 = `ref_a`, 1 = `ref_b`) starts a delayed pulse or a measurement. A pulse on the other input produces no `vref` pulse and leaves `ctrl_state` unchanged.
- R2: A selected-reference pulse in cycle c with stored delay D (`delay_val`) produces a one-cycle `vref` pulse in cycle c+1+D.
- R3: With `enable` high, a change of `sel` in cycle s sets `ctrl_state` to 1 (waiting for reference) and `freerun` to 1 in cycle s+1.
- R4: In state 1, a selected-reference pulse in cycle r moves to state 2 (measuring). A feedback pulse in cycle r+k, with 1 <= k <= TMO_CYC, gives state 3 (loading) in cycle r+k+1. Cycle r+k+2 then shows state 0, `freerun` 0 and `delay_val` = k-1.
- R5: After a load from offset k, a selected-reference pulse yields `vref` exactly k cycles later, the same offset as the measured feedback edge.
- R6: With `enable` low, `delay_val` is 0 from the next cycle on, `ctrl_state` stays 0 and a `sel` change starts no measurement.
- R7: A `clear` pulse makes `delay_val` 0 in the next cycle.
- R8: If no feedback pulse arrives by cycle r+TMO_CYC after the reference pulse in cycle r, `ctrl_state` is 0 in cycle r+TMO_CYC+1 and `delay_val` is unchanged.
- R9: A `sel` change while `ctrl_state` is nonzero restarts the sequence at state 1 for the newest selection.
- R10: `ctrl_state` encodes 0 normal, 1 waiting for reference, 2 measuring, 3 loading, and `freerun` is high exactly when it is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Correction enable |
| clear | input | 1 | Reset stored delay to zero |
| sel | input | 1 | Reference choice, 0 = ref_a, 1 = ref_b |
| ref_a | input | 1 | Primary reference edge pulse |
| ref_b | input | 1 | Secondary reference edge pulse |
| fb_pulse | input | 1 | PLL feedback edge pulse |
| vref | output | 1 | Virtual reference pulse to the PLL |
| freerun | output | 1 | Free-run mode request to the PLL |
| ctrl_state | output | 2 | Controller state code |
| delay_val | output | DLY_W | Stored delay in cycles |

## Verification
A `sel` change is visible on `ctrl_state` and `freerun` one cycle later, a measuring entry one cycle after the reference pulse, and the loading state one cycle after the feedback pulse. The new `delay_val` and the return to normal follow one cycle after that. A `vref` pulse is due D+1 cycles after its reference pulse, a clear or disable acts on `delay_val` one cycle later, and a timeout returns to normal TMO_CYC+1 cycles after the reference pulse. The bench drives each pulse for exactly one cycle on the falling edge and counts falling edges from that drive to the sample. Before it measures a `vref` latency, it idles long enough for any pulse still pending from the old delay to leave.

// File: rtl/ref_abs_pkg.sv
// Shared types for the reference-switch phase step absorber.
package ref_abs_pkg;
    // Controller state; the encoding is visible on ctrl_state.
    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_WAIT   = 2'd1,
        ST_MEAS   = 2'd2,
        ST_LOAD   = 2'd3
    } abs_state_t;
endpackage

// File: rtl/ref_abs_mux.sv
// Chooses the active reference pulse stream.
// Assumes both inputs are single-cycle pulses in the clk domain.
module ref_abs_mux (
    input  logic sel,
    input  logic ref_a,
    input  logic ref_b,
    output logic sel_ref
);
    // Pass only the chosen input.
    always_comb sel_ref = sel ? ref_b : ref_a;
endmodule

// File: rtl/ref_abs_delay.sv
// Per-edge countdown delay: a trigger in cycle c emits one out pulse in
// cycle c+1+dly. Assumes triggers are spaced wider than the delay; a new
// trigger restarts the countdown.
module ref_abs_delay #(
    parameter int DLY_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [DLY_W-1:0] dly,
    output logic             out_pulse
);
    logic [DLY_W-1:0] cnt;
    logic             busy;

    // Load on trigger, count down, fire when zero is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            busy      <= 1'b0;
            out_pulse <= 1'b0;
        end else begin
            out_pulse <= 1'b0;
            if (trig) begin
                if (dly == '0) begin
                    out_pulse <= 1'b1;
                    busy      <= 1'b0;
                end else begin
                    cnt  <= dly - 1'b1;
                    busy <= 1'b1;
                end
            end else if (busy) begin
                if (cnt == '0) begin
                    out_pulse <= 1'b1;
                    busy      <= 1'b0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ref_abs_meter.sv
// Counts cycles from a reference edge to the next feedback edge.
// The count reads 0 in the cycle after start; hit flags feedback while
// active; expired flags the last allowed cycle without feedback.
module ref_abs_meter #(
    parameter int TMO_CYC = 2000,
    localparam int MEAS_W = $clog2(TMO_CYC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              active,
    input  logic              fb,
    output logic              hit,
    output logic              expired,
    output logic [MEAS_W-1:0] count
);
    // Restart on start, advance while measuring.
    always_ff @(posedge clk) begin
        if (!rst_n)                      count <= '0;
        else if (start)                  count <= '0;
        else if (active && !hit && !expired) count <= count + 1'b1;
    end

    // Completion flags.
    always_comb begin
        hit     = active && fb;
        expired = active && !fb && (count == MEAS_W'(TMO_CYC - 1));
    end
endmodule

// File: rtl/ref_abs_ctrl.sv
// Switch controller: detects a selection change, runs the wait/measure/
// load sequence and holds the delay register. Assumes TMO_CYC <= 2**DLY_W.
module ref_abs_ctrl
    import ref_abs_pkg::*;
#(
    parameter int DLY_W  = 12,
    parameter int MEAS_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              clear,
    input  logic              sel,
    input  logic              sel_ref,
    input  logic              hit,
    input  logic              expired,
    input  logic [MEAS_W-1:0] count,
    output abs_state_t        state,
    output logic              meter_start,
    output logic [DLY_W-1:0]  dly
);
    logic             sel_q;
    logic             switch_req;
    logic [DLY_W-1:0] cap;

    // Selection change and measurement start.
    always_comb begin
        switch_req  = enable && (sel != sel_q);
        meter_start = (state == ST_WAIT) && sel_ref && !switch_req;
    end

    // Sequence state, captured offset and delay register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_NORMAL;
            sel_q <= 1'b0;
            dly   <= '0;
            cap   <= '0;
        end else begin
            sel_q <= sel;
            if (!enable) begin
                state <= ST_NORMAL;
                dly   <= '0;
            end else begin
                if (clear)                 dly <= '0;
                else if (state == ST_LOAD) dly <= cap;
                if (hit) cap <= DLY_W'(count);
                if (switch_req) begin
                    state <= ST_WAIT;
                end else begin
                    case (state)
                        ST_WAIT:  if (sel_ref) state <= ST_MEAS;
                        ST_MEAS:  if (hit) state <= ST_LOAD;
                                  else if (expired) state <= ST_NORMAL;
                        ST_LOAD:  state <= ST_NORMAL;
                        default:  state <= ST_NORMAL;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/ref_step_absorber.sv
// Top: selected reference -> programmable delay -> virtual reference,
// with a controller that re-measures the delay on every reference switch.
// Assumes all pulse inputs are synchronous single-cycle pulses.
module ref_step_absorber
    import ref_abs_pkg::*;
#(
    parameter int DLY_W   = 12,
    parameter int TMO_CYC = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             clear,
    input  logic             sel,
    input  logic             ref_a,
    input  logic             ref_b,
    input  logic             fb_pulse,
    output logic             vref,
    output logic             freerun,
    output logic [1:0]       ctrl_state,
    output logic [DLY_W-1:0] delay_val
);
    localparam int MEAS_W = $clog2(TMO_CYC);

    logic              sel_ref;
    logic              hit;
    logic              expired;
    logic              meter_start;
    logic [MEAS_W-1:0] count;
    abs_state_t        state;

    ref_abs_mux u_mux (
        .sel(sel), .ref_a(ref_a), .ref_b(ref_b), .sel_ref(sel_ref)
    );

    ref_abs_delay #(.DLY_W(DLY_W)) u_delay (
        .clk(clk), .rst_n(rst_n), .trig(sel_ref), .dly(delay_val),
        .out_pulse(vref)
    );

    ref_abs_meter #(.TMO_CYC(TMO_CYC)) u_meter (
        .clk(clk), .rst_n(rst_n), .start(meter_start),
        .active(state == ST_MEAS), .fb(fb_pulse),
        .hit(hit), .expired(expired), .count(count)
    );

    ref_abs_ctrl #(.DLY_W(DLY_W), .MEAS_W(MEAS_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear),
        .sel(sel), .sel_ref(sel_ref), .hit(hit), .expired(expired),
        .count(count), .state(state), .meter_start(meter_start),
        .dly(delay_val)
    );

    // Status and mode outputs.
    always_comb begin
        ctrl_state = state;
        freerun    = (state != ST_NORMAL);
    end
endmodule

// File: rtl/ref_step_absorber_chk.sv
// Port-level properties of the absorber, bound to every instance.
module ref_step_absorber_chk #(
    parameter int DLY_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             clear,
    input logic             sel,
    input logic             freerun,
    input logic [1:0]       ctrl_state,
    input logic [DLY_W-1:0] delay_val
);
    // R3
    switch_enters_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sel != $past(sel)) |=> (ctrl_state == 2'd1 && freerun));

    // R4
    load_returns_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state == 2'd3 && enable && sel == $past(sel)) |=> (ctrl_state == 2'd0 && !freerun));

    // R6
    disable_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (delay_val == '0 && ctrl_state == 2'd0));

    // R7
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && enable) |=> delay_val == '0);

    // R8
    delay_change_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (delay_val != $past(delay_val)) |->
            ($past(ctrl_state) == 2'd3 || $past(clear) || !$past(enable)));
endmodule

bind ref_step_absorber ref_step_absorber_chk #(.DLY_W(DLY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear), .sel(sel),
    .freerun(freerun), .ctrl_state(ctrl_state), .delay_val(delay_val)
);

// File: tb/tb_ref_step_absorber.sv
// Self-checking bench: a switch-vector table, then directed cases.
module tb_ref_step_absorber;
    localparam int DW  = 8;
    localparam int TMO = 40;
    localparam int NV  = 6;
    // Each row: new sel, reference-to-feedback offset k.
    localparam int VEC [NV][2] = '{'{1, 7}, '{0, 3}, '{1, 1},
                                   '{0, 25}, '{1, 12}, '{0, 40}};

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, clear = 1'b0, sel = 1'b0;
    logic ref_a = 1'b0, ref_b = 1'b0, fb_pulse = 1'b0;
    logic vref, freerun;
    logic [1:0] ctrl_state;
    logic [DW-1:0] delay_val;
    int nvec = 0, nfail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ref_step_absorber #(.DLY_W(DW), .TMO_CYC(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear), .sel(sel),
        .ref_a(ref_a), .ref_b(ref_b), .fb_pulse(fb_pulse), .vref(vref),
        .freerun(freerun), .ctrl_state(ctrl_state), .delay_val(delay_val)
    );

    task automatic check(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One-cycle pulse on the chosen input (0 = ref_a, 1 = ref_b).
    task automatic pulse_ref(input bit which);
        if (which) ref_b = 1'b1; else ref_a = 1'b1;
        @(negedge clk);
        ref_a = 1'b0; ref_b = 1'b0;
    endtask

    // Pulse a reference; return cycles from the pulse+1 to first vref.
    task automatic vref_latency(input bit which, output int n);
        pulse_ref(which);
        n = 0;
        while (!vref && n < 80) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        int lat;
        idle(3);
        check("R10 reset state", ctrl_state, 0);
        check("R10 reset freerun", freerun, 0);
        check("R2 reset vref", vref, 0);
        check("R7 reset delay", delay_val, 0);
        rst_n = 1'b1; enable = 1'b1;
        idle(2);

        // Table walk: switch, measure, load, then confirm the new latency.
        for (int i = 0; i < NV; i++) begin
            sel = VEC[i][0][0];
            @(negedge clk);
            check("R3 wait state", ctrl_state, 1);
            check("R3 freerun", freerun, 1);
            pulse_ref(VEC[i][0][0]);
            check("R4 measuring", ctrl_state, 2);
            idle(VEC[i][1] - 1);
            fb_pulse = 1'b1;
            @(negedge clk);
            fb_pulse = 1'b0;
            check("R4 loading", ctrl_state, 3);
            @(negedge clk);
            check("R4 normal", ctrl_state, 0);
            check("R10 freerun low", freerun, 0);
            check("R4 delay", delay_val, VEC[i][1] - 1);
            idle(50);
            vref_latency(VEC[i][0][0], lat);
            check("R5 offset", lat + 1, VEC[i][1]);
            idle(5);
        end

        // R1: unselected input gives no vref (sel=0, delay 39).
        vref_latency(1'b1, lat);
        check("R1 no vref from unselected", lat, 80);
        // R2: latency with delay 39 on selected input.
        vref_latency(1'b0, lat);
        check("R2 latency", lat, 39);
        idle(5);

        // R1 in wait state, R8 timeout.
        sel = 1'b1;
        @(negedge clk);
        pulse_ref(1'b0);
        check("R1 wait ignores unselected", ctrl_state, 1);
        pulse_ref(1'b1);
        check("R8 measuring", ctrl_state, 2);
        idle(TMO - 1);
        check("R8 still measuring", ctrl_state, 2);
        @(negedge clk);
        check("R8 timeout normal", ctrl_state, 0);
        check("R8 delay kept", delay_val, 39);

        // R9: reselect mid-measurement restarts.
        sel = 1'b0;
        @(negedge clk);
        pulse_ref(1'b0);
        check("R9 measuring", ctrl_state, 2);
        sel = 1'b1;
        @(negedge clk);
        check("R9 restart wait", ctrl_state, 1);
        pulse_ref(1'b1);
        idle(4);
        fb_pulse = 1'b1;
        @(negedge clk);
        fb_pulse = 1'b0;
        idle(1);
        check("R9 delay from newest", delay_val, 4);

        // R7: clear.
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        check("R7 cleared", delay_val, 0);
        idle(10);
        vref_latency(1'b1, lat);
        check("R7 raw latency", lat, 0);

        // R6: disable.
        sel = 1'b0;
        @(negedge clk);
        pulse_ref(1'b0);
        idle(5);
        fb_pulse = 1'b1;
        @(negedge clk);
        fb_pulse = 1'b0;
        idle(1);
        check("R4 delay before disable", delay_val, 5);
        enable = 1'b0;
        @(negedge clk);
        check("R6 delay zero", delay_val, 0);
        sel = 1'b1;
        @(negedge clk);
        check("R6 no wait", ctrl_state, 0);
        check("R6 no freerun", freerun, 0);
        idle(10);
        vref_latency(1'b1, lat);
        check("R6 raw latency", lat, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule